// File: doc/BRIEF.md
# Adjustable-Rate Time-of-Day Counter

This block keeps a precise time of day as a nanoseconds field and a seconds field. On every core clock it adds a fixed nominal step to the nanoseconds field. A signed fine-rate word is summed each clock into a 32-bit fractional accumulator. Each time that accumulator overflows, the current step grows or shrinks by one nanosecond, so software can trim the clock rate in very small amounts. When the nanoseconds field passes one second it wraps and carries into the seconds field. That rollover can drive a one-cycle pulse that serves as a once-per-second reference.

Software uses a small register port to reach the block. A read of the trigger address freezes the whole time value in a shadow copy, so the following reads of the two halves always belong together. To set the time, software stages the nanoseconds half first. Writing the seconds half then loads both halves in one edge.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset the running time, fractional accumulator, staged nanoseconds, shadow copy, rate word and pulse enable are all zero, and pps_pulse is low.
- R2: With a rate word of magnitude zero, the nanoseconds field grows by exactly NS_STEP on every clock.
- R3: The rate word at address 3 holds the sign in bit 31 (1 = slow down) and the magnitude in bits 30:0. The magnitude is added to a 32-bit fraction each clock. On a carry out of the fraction, that clock's step is NS_STEP+1 when the sign is 0 and NS_STEP-1 when the sign is 1. A newly written rate applies from the clock after the write.
- R4: When a step brings the nanoseconds field to NS_PER_SEC or above, NS_PER_SEC is subtracted and seconds increase by one. This includes the case where the extra fractional nanosecond is what crosses the boundary.
- R5: A read strobe with address 0 copies {seconds, nanoseconds} as they stand before that edge into the shadow copy. reg_rdata at address 1 shows the shadow nanoseconds and at address 2 the shadow seconds. The shadow copy does not change until the next such read.
- R6: A write to address 1 stages a nanoseconds value and leaves the running time untouched.
- R7: A write to address 2 loads seconds from the write data and nanoseconds from the staged value in one edge, and clears the fraction. Counting resumes on the next clock.
- R8: pps_pulse is high for exactly the one cycle after an edge at which seconds rolled over through R4, and only while bit 0 of address 4 is set. A load through R7 never raises it.
- R9: reg_rdata shows the rate word at address 3 and the pulse enable in bit 0 at address 4. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst | input | 1 | synchronous reset, active high |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (acts only at address 0) |
| reg_addr | input | 3 | register address |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for reg_addr |
| pps_pulse | output | 1 | one-cycle seconds rollover pulse |

## Verification
The hardest case to reach is a fractional carry that lands on the very clock where the nanoseconds field crosses one second. Counting up to that point from reset would take about a hundred million cycles. The stimulus therefore loads a time a few steps short of the boundary and picks large rate magnitudes of both signs, so carries happen on most clocks near the wrap. A bench model tracks every clock. Snapshots and the pulse output are compared against it.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;
    localparam int TW = 32;
    localparam logic [2:0] A_SNAP = 3'd0;
    localparam logic [2:0] A_NSEC = 3'd1;
    localparam logic [2:0] A_SEC  = 3'd2;
    localparam logic [2:0] A_RATE = 3'd3;
    localparam logic [2:0] A_CTRL = 3'd4;

    typedef struct packed {
        logic [TW-1:0] sec;
        logic [TW-1:0] ns;
    } tod_t;
endpackage

// File: rtl/ptpc_rate_accum.sv
module ptpc_rate_accum #(
    parameter int FRAC_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sign,
    input  logic [FRAC_W-2:0] mag,
    output logic              adj_up,
    output logic              adj_dn
);
    typedef struct packed {
        logic [FRAC_W-1:0] frac;
    } st_t;

    st_t st_d, st_q;
    logic [FRAC_W:0] sum;

    always_comb begin
        st_d   = st_q;
        sum    = {1'b0, st_q.frac} + {2'b00, mag};
        adj_up = 1'b0;
        adj_dn = 1'b0;
        if (clear) begin
            st_d.frac = '0;
        end else begin
            st_d.frac = sum[FRAC_W-1:0];
            adj_up    = sum[FRAC_W] & ~sign;
            adj_dn    = sum[FRAC_W] & sign;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_LOAD_CLEARS_FRAC: assert property (@(posedge clk) disable iff (rst)
        $past(clear) |-> st_q.frac == '0); // R7
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        !(adj_up && adj_dn)); // R3
endmodule

// File: rtl/ptpc_tod_counter.sv
module ptpc_tod_counter #(
    parameter int NS_STEP    = 8,
    parameter int NS_PER_SEC = 1000000000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [ptpc_pkg::TW-1:0] load_ns,
    input  logic [ptpc_pkg::TW-1:0] load_sec,
    input  logic                   adj_up,
    input  logic                   adj_dn,
    input  logic                   pps_en,
    output ptpc_pkg::tod_t         tod,
    output logic                   pps
);
    import ptpc_pkg::*;
    localparam logic [TW:0] STEP_V  = (TW+1)'(NS_STEP);
    localparam logic [TW:0] LIMIT_V = (TW+1)'(NS_PER_SEC);

    typedef struct packed {
        tod_t t;
        logic pps;
    } st_t;

    st_t st_d, st_q;
    logic [TW:0] sum;

    always_comb begin
        st_d     = st_q;
        st_d.pps = 1'b0;
        sum      = {1'b0, st_q.t.ns} + STEP_V + {{TW{1'b0}}, adj_up} - {{TW{1'b0}}, adj_dn};
        if (load) begin
            st_d.t.sec = load_sec;
            st_d.t.ns  = load_ns;
        end else if (sum >= LIMIT_V) begin
            st_d.t.ns  = TW'(sum - LIMIT_V);
            st_d.t.sec = st_q.t.sec + 1'b1;
            st_d.pps   = pps_en;
        end else begin
            st_d.t.ns  = sum[TW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tod = st_q.t;
    assign pps = st_q.pps;

    AST_NS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.t.ns < TW'(NS_PER_SEC)); // R4
    AST_PPS_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        st_q.pps |-> (st_q.t.sec == $past(st_q.t.sec) + 1'b1)); // R8
    AST_SEC_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> (st_q.t.sec == $past(st_q.t.sec) || st_q.t.sec == $past(st_q.t.sec) + 1'b1)); // R4
    AST_NO_PPS_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        $past(load) |-> !st_q.pps); // R8
endmodule

// File: rtl/ptpc_regif.sv
module ptpc_regif (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [2:0]              reg_addr,
    input  logic [ptpc_pkg::TW-1:0] reg_wdata,
    input  ptpc_pkg::tod_t          tod,
    output logic                    load,
    output logic [ptpc_pkg::TW-1:0] load_ns,
    output logic                    rate_sign,
    output logic [ptpc_pkg::TW-2:0] rate_mag,
    output logic                    pps_en,
    output logic [ptpc_pkg::TW-1:0] reg_rdata
);
    import ptpc_pkg::*;

    typedef struct packed {
        tod_t          snap;
        logic [TW-1:0] pend_ns;
        logic [TW-1:0] rate;
        logic          en;
    } st_t;

    st_t  st_d, st_q;
    logic trig;

    always_comb begin
        st_d = st_q;
        trig = reg_rd && (reg_addr == A_SNAP);
        if (trig) st_d.snap = tod;
        if (reg_wr) begin
            case (reg_addr)
                A_NSEC:  st_d.pend_ns = reg_wdata;
                A_RATE:  st_d.rate    = reg_wdata;
                A_CTRL:  st_d.en      = reg_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            A_NSEC:  reg_rdata = st_q.snap.ns;
            A_SEC:   reg_rdata = st_q.snap.sec;
            A_RATE:  reg_rdata = st_q.rate;
            A_CTRL:  reg_rdata = {{(TW-1){1'b0}}, st_q.en};
            default: reg_rdata = '0;
        endcase
    end

    assign load      = reg_wr && (reg_addr == A_SEC);
    assign load_ns   = st_q.pend_ns;
    assign rate_sign = st_q.rate[TW-1];
    assign rate_mag  = st_q.rate[TW-2:0];
    assign pps_en    = st_q.en;

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(trig) |-> $stable(st_q.snap)); // R5
    AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        $past(trig) |-> st_q.snap == $past(tod)); // R5
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock #(
    parameter int NS_STEP    = 8,
    parameter int NS_PER_SEC = 1000000000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        pps_pulse
);
    import ptpc_pkg::*;

    logic          load, rate_sign, pps_en, adj_up, adj_dn;
    logic [TW-1:0] load_ns;
    logic [TW-2:0] rate_mag;
    tod_t          tod;

    ptpc_regif u_regif (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .tod(tod),
        .load(load), .load_ns(load_ns), .rate_sign(rate_sign),
        .rate_mag(rate_mag), .pps_en(pps_en), .reg_rdata(reg_rdata)
    );

    ptpc_rate_accum #(.FRAC_W(TW)) u_accum (
        .clk(clk), .rst(rst), .clear(load), .sign(rate_sign),
        .mag(rate_mag), .adj_up(adj_up), .adj_dn(adj_dn)
    );

    ptpc_tod_counter #(.NS_STEP(NS_STEP), .NS_PER_SEC(NS_PER_SEC)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .load_ns(load_ns),
        .load_sec(reg_wdata), .adj_up(adj_up), .adj_dn(adj_dn),
        .pps_en(pps_en), .tod(tod), .pps(pps_pulse)
    );
endmodule

// File: tb/ptp_tod_clock_tb.sv
module ptp_tod_clock_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STEP = 8;
    localparam int NPS  = 1000000000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pps_pulse;

    int checks = 0;
    int errors = 0;

    ptp_tod_clock #(.NS_STEP(STEP), .NS_PER_SEC(NPS)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pps_pulse(pps_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model of the requirements
    logic [31:0] m_ns, m_sec, m_frac, m_pend, m_rate, m_sns, m_ssec;
    logic        m_en, m_pps;
    int          wraps;

    function automatic logic [32:0] next_ns(input logic [31:0] ns, input logic [31:0] frac,
                                            input logic [31:0] rate, output logic [31:0] nfrac);
        logic [32:0] f;
        logic [32:0] t;
        f     = {1'b0, frac} + {2'b00, rate[30:0]};
        nfrac = f[31:0];
        t     = {1'b0, ns} + 33'(STEP);
        if (f[32]) t = rate[31] ? t - 33'd1 : t + 33'd1;
        return t;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ns = 0; m_sec = 0; m_frac = 0; m_pend = 0; m_rate = 0;
            m_en = 0; m_pps = 0; m_sns = 0; m_ssec = 0;
        end else begin
            logic [32:0] t;
            logic [31:0] nf;
            if (reg_rd && reg_addr == 3'd0) begin m_sns = m_ns; m_ssec = m_sec; end
            m_pps = 1'b0;
            if (reg_wr && reg_addr == 3'd2) begin
                m_sec = reg_wdata; m_ns = m_pend; m_frac = 0;
            end else begin
                t = next_ns(m_ns, m_frac, m_rate, nf);
                m_frac = nf;
                if (t >= 33'(NPS)) begin
                    t = t - 33'(NPS); m_sec = m_sec + 1; m_pps = m_en; wraps++;
                end
                m_ns = t[31:0];
            end
            if (reg_wr && reg_addr == 3'd1) m_pend = reg_wdata;
            if (reg_wr && reg_addr == 3'd3) m_rate = reg_wdata;
            if (reg_wr && reg_addr == 3'd4) m_en = reg_wdata[0];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (pps_pulse !== m_pps) begin
                errors++;
                $display("FAIL R8 pps_pulse actual %0b expected %0b", pps_pulse, m_pps);
            end
            if (m_pps) checks++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic snap();
        reg_rd = 1; reg_addr = 3'd0;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic check_time(input string req);
        logic [31:0] lo, hi;
        snap();
        rd(3'd1, lo); check(req, lo, m_sns);
        rd(3'd2, hi); check(req, hi, m_ssec);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, lo1, hi1;
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(3'd1, v); check("R1 shadow ns", v, 0);
        rd(3'd2, v); check("R1 shadow sec", v, 0);
        rd(3'd3, v); check("R1 rate", v, 0);
        rd(3'd4, v); check("R1 enable", v, 0);
        check("R1 pps", {31'd0, pps_pulse}, 0);
        // R2 nominal step
        idle(10);
        check_time("R2 nominal");
        check("R2 step multiple", m_sns % STEP, 0);
        // R9 readback, unused address
        wr(3'd3, 32'h8000_1234); rd(3'd3, v); check("R9 rate readback", v, 32'h8000_1234);
        wr(3'd4, 32'h1);         rd(3'd4, v); check("R9 enable readback", v, 1);
        rd(3'd6, v); check("R9 unused", v, 0);
        // R6 staging does not touch running time
        wr(3'd1, 32'd123456);
        check_time("R6 stage only");
        // R7 load, R4 wrap with slow-down carry right on the boundary
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd1, NPS - 3*STEP + 2);
        wr(3'd2, 32'd77);
        idle(6);
        check_time("R4 boundary slow");
        // R4 speed-up carry crossing the boundary
        wr(3'd3, 32'h7FFF_FFFF);
        wr(3'd1, NPS - 2*STEP - 1);
        wr(3'd2, 32'hFFFF_FFFF);
        idle(5);
        check_time("R4 boundary fast");
        // R5 shadow holds while counting
        snap();
        rd(3'd1, lo1); rd(3'd2, hi1);
        idle(37);
        rd(3'd1, v); check("R5 hold ns", v, lo1);
        rd(3'd2, v); check("R5 hold sec", v, hi1);
        // R3 random rates, R4/R8 wraps
        for (int i = 0; i < 60; i++) begin
            logic [31:0] r;
            case ($urandom % 3)
                0: r = $urandom % 32'h100;
                1: r = 32'h7000_0000 | ($urandom % 32'h0FFF_FFFF);
                default: r = $urandom;
            endcase
            if ($urandom % 2) r[31] = ~r[31];
            wr(3'd3, r);
            wr(3'd4, {31'd0, 1'($urandom % 2)});
            wr(3'd1, NPS - 1 - ($urandom % 300));
            wr(3'd2, $urandom);
            idle($urandom % 80);
            check_time("R3 random rate");
        end
        check("R4 wraps seen", {31'd0, wraps > 20}, 1);
        idle(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule